// File: doc/BRIEF.md
# Last Branch and Exception Recorder

This block keeps the control-flow history that a core's debug unit needs. A retirement-side event interface reports each taken branch, and each taken exception or interrupt, along with its source and target addresses. The block holds two separate records, one for the most recent branch and one for the most recent exception or interrupt. Each record is a pair of address registers, one for the source and one for the target. Both records are updated only while the recording enable is set.

A small state machine owns the enable. It has three states:
- `ST_OFF`: recording is off after reset or after software cleared it.
- `ST_REC`: recording is active.
- `ST_FROZEN`: a debug exception has removed the enable.

The state machine has these transitions:
- `ST_OFF` to `ST_REC` on a permitted write of enable 1.
- `ST_REC` to `ST_OFF` on a permitted write of enable 0.
- `ST_REC` to `ST_FROZEN` on a debug exception.
- `ST_FROZEN` to `ST_REC` on a permitted write of enable 1.
- `ST_FROZEN` to `ST_OFF` on a permitted write of enable 0.

A debug exception forces `ST_FROZEN` (or leaves `ST_OFF` unchanged) and takes priority over a control write in the same cycle. Because hardware removes the enable itself, the records stay frozen at the debug event until the debugger reads them.

A register port reads and writes the block. Only privilege level 0, or real-address mode, may change the control register. Any other write attempt is dropped and pulses a fault strobe for one cycle. Reads are open at any privilege level and return data one cycle after the request. Two extra read addresses return each record packed into 64 bits.

Top module: `cf_history_recorder`

## Requirements
- R1: After reset, the enable reads 0 and all four address registers read 0.
- R2: The control register is at address 0, and its bit 0 is the recording enable. A read of it returns the enable in bit 0 and zero in every other bit, whatever value was written.
- R3: While enabled, a taken branch (`br_valid`) replaces the branch source and target registers (addresses 1 and 2). While disabled, a branch leaves them unchanged.
- R4: While enabled, a taken exception or interrupt (`ex_valid`) replaces the exception source and target registers (addresses 3 and 4). The branch record is not affected.
- R5: A debug exception (`dbg_exc`) clears the enable. Events after it do not change either record.
- R6: An event in the same cycle as `dbg_exc` is recorded, and the enable clears afterwards. An exception flagged `ex_is_debug` does not overwrite the exception record.
- R7: A write changes the control register only when `priv_lvl` is 0 or `real_mode` is 1. Any other write is ignored and raises `wr_fault` for exactly one cycle.
- R8: A read at any privilege level sets `rd_valid` in the next cycle, with `rd_data` holding the register contents from the cycle of the request. `rd_valid` stays low when no read was made.
- R9: Address 5 returns the branch record packed as source in bits 63:32 and target in bits 31:0. Address 6 returns the exception record in the same layout.
- R10: A permitted write to any address other than 0 leaves every register unchanged.
- R11: When a debug exception and a permitted control write arrive in the same cycle, the enable reads 0 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| br_valid | input | 1 | Taken branch retired this cycle |
| br_from | input | 32 | Branch source address |
| br_to | input | 32 | Branch target address |
| ex_valid | input | 1 | Taken exception or interrupt this cycle |
| ex_from | input | 32 | Exception source address |
| ex_to | input | 32 | Exception handler address |
| ex_is_debug | input | 1 | The reported exception is itself a debug exception |
| dbg_exc | input | 1 | Debug exception (breakpoint or single-step) occurs |
| reg_wr | input | 1 | Register write request |
| reg_rd | input | 1 | Register read request |
| reg_addr | input | 3 | Register address (0 control, 1 to 4 addresses, 5 and 6 packed records) |
| reg_wdata | input | 32 | Write data |
| priv_lvl | input | 2 | Requester privilege level |
| real_mode | input | 1 | Core is in real-address mode |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 64 | Read data |
| wr_fault | output | 1 | One-cycle strobe for a refused write |

## Verification
The bench sends branches and exceptions alone, together, and while the block is disabled or frozen. This shows that each record is captured only when it should be, and that the two records never disturb each other. It places a debug exception in the same cycle as a branch, as a debug-flagged exception, and as a privileged control write. These cases separate "record first, then freeze" from "freeze first", and show that the debug exception wins over software. It writes the control register at privilege 3 with real-address mode both off and on, which confirms that the mode alone is enough to permit a write. It writes all-ones with reserved bits set, and writes to address registers, to show that only bit 0 of the control register is writable.

// File: rtl/cfh_pkg.sv
package cfh_pkg;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTL    = 3'd0;
    localparam logic [ADDR_W-1:0] A_BR_SRC = 3'd1;
    localparam logic [ADDR_W-1:0] A_BR_DST = 3'd2;
    localparam logic [ADDR_W-1:0] A_EX_SRC = 3'd3;
    localparam logic [ADDR_W-1:0] A_EX_DST = 3'd4;
    localparam logic [ADDR_W-1:0] A_BR_PK  = 3'd5;
    localparam logic [ADDR_W-1:0] A_EX_PK  = 3'd6;

    typedef enum logic [1:0] {
        ST_OFF    = 2'd0,
        ST_REC    = 2'd1,
        ST_FROZEN = 2'd2
    } rec_state_e;

    localparam int KINDS   = 2;
    localparam int K_BR    = 0;
    localparam int K_EX    = 1;
endpackage

// File: rtl/cfh_ctl_fsm.sv
module cfh_ctl_fsm
    import cfh_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic dbg_exc,
    input  logic wr_any,
    input  logic wr_ctl,
    input  logic wr_bit,
    input  logic priv_ok,
    output logic rec_en,
    output logic wr_fault
);
    rec_state_e state_q, state_d;
    logic       fault_q;

    // next-state logic: a debug exception outranks any software write
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (!dbg_exc && wr_ctl && priv_ok && wr_bit)
                    state_d = ST_REC;
            end
            ST_REC: begin
                if (dbg_exc)
                    state_d = ST_FROZEN;
                else if (wr_ctl && priv_ok && !wr_bit)
                    state_d = ST_OFF;
            end
            ST_FROZEN: begin
                if (!dbg_exc && wr_ctl && priv_ok)
                    state_d = wr_bit ? ST_REC : ST_OFF;
            end
            default: state_d = ST_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_OFF;
        else
            state_q <= state_d;
    end

    // output process
    always_ff @(posedge clk) begin
        if (!rst_n)
            fault_q <= 1'b0;
        else
            fault_q <= wr_any && !priv_ok;
    end

    always_comb begin
        rec_en   = (state_q == ST_REC);
        wr_fault = fault_q;
    end

    // R5: a debug exception always leaves recording off
    a_r5_dbg_clears: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_exc |=> !rec_en);

    // R7: a refused write strobes the fault output
    a_r7_fault_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && !priv_ok) |=> wr_fault);

    // R7: a refused control write does not move the enable
    a_r7_unpriv_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_ctl && !priv_ok && !dbg_exc) |=> $stable(rec_en));

    // R11: debug exception wins over a simultaneous permitted write
    a_r11_dbg_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_exc && wr_ctl && priv_ok) |=> (state_q != ST_REC));
endmodule

// File: rtl/cfh_record.sv
module cfh_record #(
    parameter int AW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cap,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    output logic [AW-1:0] src_q,
    output logic [AW-1:0] dst_q
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q <= '0;
            dst_q <= '0;
        end else if (cap) begin
            src_q <= src_i;
            dst_q <= dst_i;
        end
    end

    // R3/R4: a record holds whenever it is not captured
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !cap |=> ($stable(src_q) && $stable(dst_q)));

    // R4: a capture stores the presented addresses
    a_r4_capture: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> (src_q == $past(src_i) && dst_q == $past(dst_i)));
endmodule

// File: rtl/cfh_read_port.sv
module cfh_read_port
    import cfh_pkg::*;
#(
    parameter int AW = 32,
    localparam int DW = 2 * AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              rec_en,
    input  logic [AW-1:0]     br_src,
    input  logic [AW-1:0]     br_dst,
    input  logic [AW-1:0]     ex_src,
    input  logic [AW-1:0]     ex_dst,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data
);
    logic [DW-1:0] sel;

    always_comb begin
        sel = '0;
        case (reg_addr)
            A_CTL:    sel = {{(DW-1){1'b0}}, rec_en};
            A_BR_SRC: sel = {{AW{1'b0}}, br_src};
            A_BR_DST: sel = {{AW{1'b0}}, br_dst};
            A_EX_SRC: sel = {{AW{1'b0}}, ex_src};
            A_EX_DST: sel = {{AW{1'b0}}, ex_dst};
            A_BR_PK:  sel = {br_src, br_dst};
            A_EX_PK:  sel = {ex_src, ex_dst};
            default:  sel = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= reg_rd;
            if (reg_rd)
                rd_data <= sel;
        end
    end

    // R8: one-cycle read latency, no spurious valid
    a_r8_latency: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rd |=> rd_valid);
    a_r8_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !reg_rd |=> !rd_valid);
endmodule

// File: rtl/cf_history_recorder.sv
module cf_history_recorder
    import cfh_pkg::*;
#(
    parameter int AW = 32,
    localparam int DW = 2 * AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_valid,
    input  logic [AW-1:0]     br_from,
    input  logic [AW-1:0]     br_to,
    input  logic              ex_valid,
    input  logic [AW-1:0]     ex_from,
    input  logic [AW-1:0]     ex_to,
    input  logic              ex_is_debug,
    input  logic              dbg_exc,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [AW-1:0]     reg_wdata,
    input  logic [1:0]        priv_lvl,
    input  logic              real_mode,
    output logic              rd_valid,
    output logic [DW-1:0]     rd_data,
    output logic              wr_fault
);
    logic          rec_en;
    logic          priv_ok;
    logic          wr_ctl;
    logic          unused_wdata;
    logic [KINDS-1:0]         cap;
    logic [KINDS-1:0][AW-1:0] ev_src, ev_dst, rec_src, rec_dst;

    assign priv_ok      = (priv_lvl == 2'd0) || real_mode;
    assign wr_ctl       = reg_wr && (reg_addr == A_CTL);
    assign unused_wdata = ^reg_wdata[AW-1:1];

    cfh_ctl_fsm u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .dbg_exc  (dbg_exc),
        .wr_any   (reg_wr),
        .wr_ctl   (wr_ctl),
        .wr_bit   (reg_wdata[0]),
        .priv_ok  (priv_ok),
        .rec_en   (rec_en),
        .wr_fault (wr_fault)
    );

    // capture qualifiers use the enable as it stands this cycle
    always_comb begin
        cap[K_BR]    = rec_en && br_valid;
        cap[K_EX]    = rec_en && ex_valid && !ex_is_debug;
        ev_src[K_BR] = br_from;
        ev_dst[K_BR] = br_to;
        ev_src[K_EX] = ex_from;
        ev_dst[K_EX] = ex_to;
    end

    for (genvar k = 0; k < KINDS; k++) begin : g_rec
        cfh_record #(.AW(AW)) u_rec (
            .clk   (clk),
            .rst_n (rst_n),
            .cap   (cap[k]),
            .src_i (ev_src[k]),
            .dst_i (ev_dst[k]),
            .src_q (rec_src[k]),
            .dst_q (rec_dst[k])
        );
    end

    cfh_read_port #(.AW(AW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .reg_rd   (reg_rd),
        .reg_addr (reg_addr),
        .rec_en   (rec_en),
        .br_src   (rec_src[K_BR]),
        .br_dst   (rec_dst[K_BR]),
        .ex_src   (rec_src[K_EX]),
        .ex_dst   (rec_dst[K_EX]),
        .rd_valid (rd_valid),
        .rd_data  (rd_data)
    );

    // R6: a debug-flagged exception never lands in the exception record
    a_r6_dbg_not_recorded: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_is_debug) |=> ($stable(rec_src[K_EX]) && $stable(rec_dst[K_EX])));

    // R3: a branch while disabled leaves the branch record alone
    a_r3_off_no_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (!rec_en) |=> ($stable(rec_src[K_BR]) && $stable(rec_dst[K_BR])));
endmodule

// File: tb/tb_cf_history_recorder.sv
module tb_cf_history_recorder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_valid = 1'b0, ex_valid = 1'b0, ex_is_debug = 1'b0, dbg_exc = 1'b0;
    logic [31:0] br_from = '0, br_to = '0, ex_from = '0, ex_to = '0, reg_wdata = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0, real_mode = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [1:0]  priv_lvl = 2'd3;
    logic        rd_valid, wr_fault;
    logic [63:0] rd_data;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    // expected model, kept from the requirements
    bit          m_en = 1'b0;
    logic [31:0] m_bf = '0, m_bt = '0, m_ef = '0, m_et = '0;

    logic [63:0] exp_q[$];
    string       tag_q[$];

    cf_history_recorder dut (
        .clk(clk), .rst_n(rst_n),
        .br_valid(br_valid), .br_from(br_from), .br_to(br_to),
        .ex_valid(ex_valid), .ex_from(ex_from), .ex_to(ex_to),
        .ex_is_debug(ex_is_debug), .dbg_exc(dbg_exc),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .priv_lvl(priv_lvl), .real_mode(real_mode),
        .rd_valid(rd_valid), .rd_data(rd_data), .wr_fault(wr_fault)
    );

    always #2 clk = ~clk; // 4 ns period, 250 MHz

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // monitor: pop expected read results as the design returns them
    always @(negedge clk) begin
        if (rst_n && rd_valid) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected rd_valid", 64'd1, 64'd0);
            end else begin
                automatic logic [63:0] e = exp_q.pop_front();
                automatic string t = tag_q.pop_front();
                check(rd_data === e, t, rd_data, e);
            end
        end
    end

    task automatic idle();
        br_valid = 0; ex_valid = 0; ex_is_debug = 0; dbg_exc = 0;
        reg_wr = 0; reg_rd = 0; reg_addr = '0; reg_wdata = '0;
        priv_lvl = 2'd3; real_mode = 0;
    endtask

    // one stimulus cycle; model updated with the old enable first
    task automatic step(input bit bv, input logic [31:0] bf, input logic [31:0] bt,
                        input bit ev, input logic [31:0] ef, input logic [31:0] et,
                        input bit isd, input bit dbg,
                        input bit wr, input logic [2:0] a, input logic [31:0] wd,
                        input logic [1:0] pl, input bit rm);
        @(posedge clk); #1;
        br_valid = bv; br_from = bf; br_to = bt;
        ex_valid = ev; ex_from = ef; ex_to = et;
        ex_is_debug = isd; dbg_exc = dbg;
        reg_wr = wr; reg_addr = a; reg_wdata = wd; priv_lvl = pl; real_mode = rm;
        if (bv && m_en) begin m_bf = bf; m_bt = bt; end
        if (ev && m_en && !isd) begin m_ef = ef; m_et = et; end
        if (dbg) m_en = 0;
        else if (wr && a == 3'd0 && (pl == 2'd0 || rm)) m_en = wd[0];
        @(posedge clk); #1;
        idle();
    endtask

    task automatic wr_ctl(input logic [31:0] wd, input logic [1:0] pl, input bit rm);
        step(0, '0, '0, 0, '0, '0, 0, 0, 1, 3'd0, wd, pl, rm);
    endtask

    task automatic rd(input logic [2:0] a, input logic [63:0] e, input string t);
        @(posedge clk); #1;
        reg_rd = 1; reg_addr = a; priv_lvl = 2'd3;
        exp_q.push_back(e);
        tag_q.push_back(t);
        @(posedge clk); #1;
        idle();
    endtask

    task automatic rd_all(input string t);
        rd(3'd0, {63'd0, m_en}, {t, " ctl"});
        rd(3'd1, {32'd0, m_bf}, {t, " br_src"});
        rd(3'd2, {32'd0, m_bt}, {t, " br_dst"});
        rd(3'd3, {32'd0, m_ef}, {t, " ex_src"});
        rd(3'd4, {32'd0, m_et}, {t, " ex_dst"});
        rd(3'd5, {m_bf, m_bt}, {t, " R9 br packed"});
        rd(3'd6, {m_ef, m_et}, {t, " R9 ex packed"});
    endtask

    initial begin
        #400000;
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        idle();
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1: reset contents
        rd_all("R1 reset");

        // R3: branch while disabled is ignored
        step(1, 32'h1111_0000, 32'h2222_0000, 0, '0, '0, 0, 0, 0, 3'd0, '0, 2'd0, 0);
        rd(3'd1, 64'd0, "R3 disabled branch src");

        // R2: all-ones write, only bit 0 survives
        wr_ctl(32'hFFFF_FFFF, 2'd0, 0);
        rd(3'd0, 64'd1, "R2 reserved bits zero");

        // R3/R9: branch captured
        step(1, 32'hA000_0010, 32'hA000_0400, 0, '0, '0, 0, 0, 0, 3'd0, '0, 2'd3, 0);
        rd_all("R3 branch");

        // R4: exception captured, branch record untouched
        step(0, '0, '0, 1, 32'hB000_0020, 32'h0000_0E00, 0, 0, 0, 3'd0, '0, 2'd3, 0);
        rd_all("R4 exception");

        // R4: branch and exception in one cycle
        step(1, 32'hC100_0000, 32'hC200_0000, 1, 32'hC300_0000, 32'hC400_0000, 0, 0, 0, 3'd0, '0, 2'd3, 0);
        rd_all("R4 joint");

        // R7: refused write at privilege 3, fault for exactly one cycle
        wr_ctl(32'h0, 2'd3, 0);
        @(negedge clk);
        check(wr_fault === 1'b1, "R7 fault pulse", {63'd0, wr_fault}, 64'd1);
        @(negedge clk);
        check(wr_fault === 1'b0, "R7 fault one cycle", {63'd0, wr_fault}, 64'd0);
        rd(3'd0, 64'd1, "R7 refused write kept enable");

        // R7: real-address mode allows a write at privilege 3
        wr_ctl(32'h0, 2'd3, 1);
        @(negedge clk);
        check(wr_fault === 1'b0, "R7 no fault in real mode", {63'd0, wr_fault}, 64'd0);
        rd(3'd0, 64'd0, "R7 real mode write");
        wr_ctl(32'h1, 2'd0, 0);

        // R10: write to an address register is ignored
        step(0, '0, '0, 0, '0, '0, 0, 0, 1, 3'd1, 32'hDEAD_BEEF, 2'd0, 0);
        rd(3'd1, {32'd0, m_bf}, "R10 address reg not writable");

        // R6/R5: branch and debug-flagged exception with debug exception
        step(1, 32'hD000_0004, 32'hD000_0800, 1, 32'hD000_0004, 32'h0000_0D00, 1, 1, 0, 3'd0, '0, 2'd3, 0);
        rd_all("R6 same cycle");

        // R5: frozen, later events do nothing
        step(1, 32'hE000_0000, 32'hE000_0004, 1, 32'hE100_0000, 32'hE100_0004, 0, 0, 0, 3'd0, '0, 2'd3, 0);
        rd_all("R5 frozen");

        // R5: re-arm from frozen, capture again
        wr_ctl(32'h1, 2'd0, 0);
        step(0, '0, '0, 1, 32'hF000_0100, 32'hF000_0200, 0, 0, 0, 3'd0, '0, 2'd3, 0);
        rd_all("R5 rearmed");

        // R11: debug exception together with a permitted enable write
        step(0, '0, '0, 0, '0, '0, 0, 1, 1, 3'd0, 32'h1, 2'd0, 0);
        rd(3'd0, 64'd0, "R11 debug wins");

        // R8: no stray read data
        repeat (3) @(posedge clk);
        #1;
        check(exp_q.size() == 0, "R8 all reads returned", exp_q.size(), 64'd0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule